// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. It watches single-cycle write strobes that carry an 18-bit address and an 8-bit data byte. It recognises the multi-write unlock sequences that select an embedded operation. When a sequence completes, it raises a one-cycle start pulse for byte program, chip erase, sector erase or boot-block lockout set. It also hands over the address and data of the final write.

The decoder keeps track of its mode: read array, product identification, or busy. It stays busy from a start pulse until an external operation engine returns a done pulse. While it is busy, every write is discarded.

In identification mode a combinational read port returns one of three values, chosen by the low address bits: the manufacturer code, the device code, or the boot-block lockout status. The decoder also refuses to start a program or sector erase that targets the boot block while that block is locked.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset is asserted (rst_n low, asynchronous), mode is 2'b00 (read array), all start pulses are low and id_data is 8'h00.
- R2: The writes AA@5555, 55@2AAA, A0@5555, then D@A raise start_prog for exactly the cycle after the fourth write. In that cycle op_addr is A, op_data is D and mode is 2'b10 (busy).
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 raise start_chip in the cycle after the sixth write, and mode becomes busy.
- R4: The same five-write erase prefix followed by 30 at any address A raises start_sect in the cycle after the sixth write, with op_addr equal to A.
- R5: The five-write erase prefix followed by 40@5555 raises start_lock in the cycle after the sixth write.
- R6: The writes AA@5555, 55@2AAA, 90@5555 set mode to 2'b01 (identification). In that mode id_data is selected by addr[1:0]: 00 gives MFR_CODE (8'hDA), 01 gives DEV_CODE (8'h0B), 10 gives {7'b0, boot_locked}, and 11 gives 8'h00. Outside that mode id_data is 8'h00.
- R7: Identification mode is left, back to read array, either by AA@5555, 55@2AAA, F0@5555, or by a single F0 write at any address.
- R8: The unlock and command addresses are compared on addr[14:0] only; addr[17:15] has no effect on that comparison.
- R9: A write whose address or data does not match the next expected step discards the partial sequence and clears identification mode. The write after it is decoded as the first write of a new sequence.
- R10: While mode is busy, writes produce no start pulse and do not change the mode. An eng_done pulse while busy returns mode to read array in the next cycle.
- R11: While boot_locked is high, a program or sector erase whose target address lies in 0x3C000..0x3FFFF produces no start pulse and leaves the decoder in read array.
- R12: Asserting rst_n while busy aborts the operation: mode reads read array after reset.
- R13: At most one start pulse is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe; addr and wdata are sampled with it |
| addr | input | 18 | Write address, also the identification read address |
| wdata | input | 8 | Write data |
| boot_locked | input | 1 | Boot-block lockout status held outside the decoder |
| eng_done | input | 1 | Done pulse from the operation engine |
| start_prog | output | 1 | Start byte program |
| start_chip | output | 1 | Start chip erase |
| start_sect | output | 1 | Start sector erase |
| start_lock | output | 1 | Start boot-block lockout set |
| op_addr | output | 18 | Address of the write that completed the sequence |
| op_data | output | 8 | Data of the write that completed the sequence |
| mode | output | 2 | 00 read array, 01 identification, 10 busy |
| id_data | output | 8 | Identification read data |

## Verification
The bench feeds sequences that break off at the third write and at a wrong unlock address, and then checks that the very next write is not taken as a continuation. A decoder that kept partial state would fire a stray program pulse there.

It also sends a full command while the decoder is busy. A design that dropped the busy gate would issue a second start.

Unlock addresses are sent with the upper bits set. A decoder that compared the full address would then never arm.

Boot-block targets are sent with the lock both high and low, and a reset is applied in the middle of an operation. A design that skipped either case would emit a forbidden erase or remain stuck busy.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 18,
  parameter int DW = 8,
  parameter int CW = 15,
  parameter logic [DW-1:0] MFR_CODE = 8'hDA,
  parameter logic [DW-1:0] DEV_CODE = 8'h0B,
  parameter logic [AW-1:0] BOOT_BASE = 18'h3C000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          boot_locked,
  input  logic          eng_done,
  output logic          start_prog,
  output logic          start_chip,
  output logic          start_sect,
  output logic          start_lock,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic [1:0]    mode,
  output logic [DW-1:0] id_data
);

  localparam logic [CW-1:0] KEY_A1 = 15'h5555;
  localparam logic [CW-1:0] KEY_A2 = 15'h2AAA;
  localparam logic [DW-1:0] KEY_D1 = 8'hAA;
  localparam logic [DW-1:0] KEY_D2 = 8'h55;
  localparam logic [DW-1:0] CMD_PGM = 8'hA0;
  localparam logic [DW-1:0] CMD_ERA = 8'h80;
  localparam logic [DW-1:0] CMD_ID  = 8'h90;
  localparam logic [DW-1:0] CMD_EXIT = 8'hF0;
  localparam logic [DW-1:0] CMD_CHIP = 8'h10;
  localparam logic [DW-1:0] CMD_SECT = 8'h30;
  localparam logic [DW-1:0] CMD_LOCK = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_ERA, ST_E1, ST_E2
  } step_t;

  step_t step, nxt_step;
  logic  id_mode, nxt_id, busy;
  logic  go_prog, go_chip, go_sect, go_lock, go_any;

  wire accept  = wr_stb && !busy;
  wire at_a1   = addr[CW-1:0] == KEY_A1;
  wire at_a2   = addr[CW-1:0] == KEY_A2;
  wire unl1    = at_a1 && wdata == KEY_D1;
  wire unl2    = at_a2 && wdata == KEY_D2;
  wire blocked = boot_locked && addr >= BOOT_BASE;

  always_comb begin
    nxt_step = ST_IDLE;
    nxt_id   = 1'b0;
    go_prog  = 1'b0;
    go_chip  = 1'b0;
    go_sect  = 1'b0;
    go_lock  = 1'b0;
    unique case (step)
      ST_IDLE: if (unl1) begin
        nxt_step = ST_U1;
        nxt_id   = id_mode;
      end
      ST_U1: if (unl2) begin
        nxt_step = ST_U2;
        nxt_id   = id_mode;
      end
      ST_U2: if (at_a1) begin
        if (wdata == CMD_PGM) begin
          nxt_step = ST_PGM;
          nxt_id   = id_mode;
        end else if (wdata == CMD_ERA) begin
          nxt_step = ST_ERA;
          nxt_id   = id_mode;
        end else if (wdata == CMD_ID) begin
          nxt_id = 1'b1;
        end
      end
      ST_PGM: go_prog = !blocked;
      ST_ERA: if (unl1) begin
        nxt_step = ST_E1;
        nxt_id   = id_mode;
      end
      ST_E1: if (unl2) begin
        nxt_step = ST_E2;
        nxt_id   = id_mode;
      end
      ST_E2: begin
        if (wdata == CMD_SECT) go_sect = !blocked;
        else if (at_a1 && wdata == CMD_CHIP) go_chip = 1'b1;
        else if (at_a1 && wdata == CMD_LOCK) go_lock = 1'b1;
      end
      default: nxt_step = ST_IDLE;
    endcase
    go_any = go_prog || go_chip || go_sect || go_lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step       <= ST_IDLE;
      id_mode    <= 1'b0;
      busy       <= 1'b0;
      start_prog <= 1'b0;
      start_chip <= 1'b0;
      start_sect <= 1'b0;
      start_lock <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      start_prog <= accept && go_prog;
      start_chip <= accept && go_chip;
      start_sect <= accept && go_sect;
      start_lock <= accept && go_lock;
      if (busy) begin
        if (eng_done) busy <= 1'b0;
      end else if (wr_stb) begin
        step    <= nxt_step;
        id_mode <= nxt_id;
        if (go_any) begin
          busy    <= 1'b1;
          op_addr <= addr;
          op_data <= wdata;
        end
      end
    end
  end

  assign mode = busy ? 2'b10 : (id_mode ? 2'b01 : 2'b00);

  always_comb begin
    id_data = '0;
    if (id_mode && !busy) begin
      case (addr[1:0])
        2'd0: id_data = MFR_CODE;
        2'd1: id_data = DEV_CODE;
        2'd2: id_data = {{(DW-1){1'b0}}, boot_locked};
        default: id_data = '0;
      endcase
    end
  end

  a_r13_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_chip, start_sect, start_lock}));

  a_r13_prog_width: assert property (@(posedge clk) disable iff (!rst_n)
    start_prog |=> !start_prog);

  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && wr_stb) |=> !(start_prog || start_chip || start_sect || start_lock));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_chip || start_sect || start_lock) |-> mode == 2'b10);

  a_r10_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && eng_done) |=> mode == 2'b00);

  a_r11_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
    start_sect |-> !($past(boot_locked) && op_addr >= BOOT_BASE));

endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [17:0] addr = '0;
  logic [7:0] wdata = '0;
  logic boot_locked = 1'b0;
  logic eng_done = 1'b0;
  logic start_prog, start_chip, start_sect, start_lock;
  logic [17:0] op_addr;
  logic [7:0] op_data;
  logic [1:0] mode;
  logic [7:0] id_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct packed { logic [1:0] kind; logic [17:0] a; logic [7:0] d; } ev_t;
  ev_t expq[$];

  always #4 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
    .boot_locked(boot_locked), .eng_done(eng_done),
    .start_prog(start_prog), .start_chip(start_chip), .start_sect(start_sect),
    .start_lock(start_lock), .op_addr(op_addr), .op_data(op_data),
    .mode(mode), .id_data(id_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (start_prog || start_chip || start_sect || start_lock)) begin
      ev_t got, want;
      got.kind = start_prog ? 2'd0 : start_chip ? 2'd1 : start_sect ? 2'd2 : 2'd3;
      got.a = op_addr;
      got.d = op_data;
      if (expq.size() == 0) begin
        check("R13 unexpected start", {4'h0, got}, 32'hFFFF_FFFF);
      end else begin
        want = expq.pop_front();
        check("R2-R5 start event", {4'h0, got}, {4'h0, want});
      end
    end
  end

  task automatic wr(logic [17:0] a, logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic push(logic [1:0] k, logic [17:0] a, logic [7:0] d);
    ev_t e;
    e.kind = k; e.a = a; e.d = d;
    expq.push_back(e);
  endtask

  task automatic unlock();
    wr(18'h05555, 8'hAA);
    wr(18'h02AAA, 8'h55);
  endtask

  task automatic erase_pre();
    unlock();
    wr(18'h05555, 8'h80);
    unlock();
  endtask

  task automatic done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic rd_id(string req, logic [17:0] a, logic [7:0] exp);
    @(negedge clk); addr = a;
    #1 check(req, id_data, exp);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mode", mode, 2'b00);
    check("R1 pulses", {start_prog, start_chip, start_sect, start_lock}, 4'b0);
    check("R1 id_data", id_data, 8'h00);
    rst_n = 1'b1;

    // R2 program
    unlock(); wr(18'h05555, 8'hA0);
    push(2'd0, 18'h01234, 8'h5A);
    wr(18'h01234, 8'h5A);
    check("R2 busy", mode, 2'b10);
    @(negedge clk);
    check("R13 prog width", start_prog, 1'b0);

    // R10 writes ignored while busy
    unlock(); wr(18'h05555, 8'hA0); wr(18'h00100, 8'h11);
    check("R10 still busy", mode, 2'b10);
    done();
    check("R10 done to read", mode, 2'b00);

    // R3 chip erase
    erase_pre(); push(2'd1, 18'h05555, 8'h10); wr(18'h05555, 8'h10);
    check("R3 busy", mode, 2'b10);
    done();

    // R4 sector erase
    erase_pre(); push(2'd2, 18'h20010, 8'h30); wr(18'h20010, 8'h30);
    check("R4 busy", mode, 2'b10);
    done();

    // R5 lockout set
    erase_pre(); push(2'd3, 18'h05555, 8'h40); wr(18'h05555, 8'h40);
    check("R5 busy", mode, 2'b10);
    done();

    // R6 identification
    boot_locked = 1'b1;
    unlock(); wr(18'h05555, 8'h90);
    check("R6 id mode", mode, 2'b01);
    rd_id("R6 mfr", 18'h00000, 8'hDA);
    rd_id("R6 dev", 18'h00001, 8'h0B);
    rd_id("R6 lock", 18'h00002, 8'h01);
    rd_id("R6 off3", 18'h00003, 8'h00);
    boot_locked = 1'b0;
    rd_id("R6 unlock", 18'h00002, 8'h00);

    // R7 single-write exit
    wr(18'h12345, 8'hF0);
    check("R7 single exit", mode, 2'b00);
    rd_id("R6 outside id", 18'h00000, 8'h00);
    // R7 three-write exit
    unlock(); wr(18'h05555, 8'h90);
    check("R7 reenter", mode, 2'b01);
    unlock(); wr(18'h05555, 8'hF0);
    check("R7 triple exit", mode, 2'b00);

    // R8 upper address bits ignored
    wr(18'h35555, 8'hAA); wr(18'h1AAAA, 8'h55); wr(18'h3D555, 8'hA0);
    push(2'd0, 18'h00777, 8'h3C); wr(18'h00777, 8'h3C);
    check("R8 program armed", mode, 2'b10);
    done();

    // R9 wrong data at third write, then lone remainder
    unlock(); wr(18'h05555, 8'h77);
    wr(18'h05555, 8'hA0); wr(18'h00200, 8'h22);
    check("R9 no program after bad data", mode, 2'b00);
    // R9 wrong unlock address
    wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00300, 8'h33);
    check("R9 no program after bad addr", mode, 2'b00);
    // R9 wrong order
    wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hAA); wr(18'h05555, 8'hA0);
    check("R9 wrong order", mode, 2'b00);
    // R9 deviation clears identification mode
    unlock(); wr(18'h05555, 8'h90);
    wr(18'h00004, 8'h12);
    check("R9 id cleared", mode, 2'b00);

    // R11 boot block guard
    boot_locked = 1'b1;
    unlock(); wr(18'h05555, 8'hA0); wr(18'h3C100, 8'h00);
    check("R11 program refused", mode, 2'b00);
    erase_pre(); wr(18'h3FFFF, 8'h30);
    check("R11 sector refused", mode, 2'b00);
    boot_locked = 1'b0;
    erase_pre(); push(2'd2, 18'h3C000, 8'h30); wr(18'h3C000, 8'h30);
    check("R11 sector allowed unlocked", mode, 2'b10);
    done();

    // R12 reset aborts busy
    unlock(); wr(18'h05555, 8'hA0);
    push(2'd0, 18'h00400, 8'h44); wr(18'h00400, 8'h44);
    check("R12 busy before reset", mode, 2'b10);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R12 mode after reset", mode, 2'b00);

    repeat (3) @(negedge clk);
    check("R13 all expected starts seen", expq.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule